// File: doc/BRIEF.md
# Host Port Attach, Reset and Chirp Sequencer

This block runs the timed line-level protocol of one host-side downstream port. It debounces device attach and removal. It drives the bus reset. It also runs the speed-negotiation handshake inside that reset, in which the device signals a sustained K and the host answers with an alternating K/J train. The block also times the host-driven resume signal. The transceiver supplies the line-state code and a removal-threshold flag. A free-running tick enable is the time base, and every interval is a parameter counted in ticks. With the default values, one tick is taken as 1/60 µs.

The port controller raises a one-cycle reset or resume request while the port is attached and idle. The block then sets one of four drive requests to the transceiver. It ends each sequence with a one-cycle completion pulse. At the end of a reset it reports whether high-speed operation was negotiated. Removal cancels whatever is in progress.

Top module: `port_seq_top`

## Requirements
- R1: `line_st` encodes the line as 2'b00 SE0, 2'b01 J, 2'b10 K. From the detached state, `connected` rises only after J has been seen on CONN_TICKS consecutive tick cycles. A shorter J run leaves the port detached.
- R2: `disc_det` held for DISC_TICKS consecutive tick cycles returns the port to the detached state from any state. This clears `connected` and `hs_en`, drops every drive request and produces no `done`. A shorter pulse changes nothing.
- R3: A reset drives `drv_se0` for RESET_TICKS tick cycles in total, minus any chirp cycles. It ends with `done` high for exactly one cycle. If the sequence has no accepted device K, `hs_en` reads 0 after it, even if it was 1 before.
- R4: A device K (2'b10) during reset counts only after it has been held for DEVK_TICKS consecutive tick cycles. A shorter K leaves the reset as a plain SE0 reset.
- R5: In the cycle after an accepted device K ends, the host starts its chirp train with `drv_chirp_k`. The train then alternates K and J, each for SLOT_TICKS tick cycles.
- R6: The train stops when TAIL_TICKS of the reset remain, and SE0 is driven to the end. `hs_en` rises in the same cycle as `done`.
- R7: A resume drives `drv_resume_k` for RESUME_TICKS tick cycles and then pulses `done`. It leaves `hs_en` unchanged.
- R8: `reset_req` and `resume_req` are ignored while a reset or resume is running and while the port is detached.
- R9: Every timer advances only in cycles with `tick` high. Cycles without a tick lengthen the drive by the same number of cycles.
- R10: At most one drive request is active at a time. None is active, and `hs_en` is 0, while `connected` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable for all timers |
| line_st | input | 2 | Received line state (00 SE0, 01 J, 10 K) |
| disc_det | input | 1 | Removal threshold exceeded |
| reset_req | input | 1 | Start a bus reset |
| resume_req | input | 1 | Start resume signalling |
| drv_se0 | output | 1 | Drive SE0 request |
| drv_chirp_k | output | 1 | Drive chirp K request |
| drv_chirp_j | output | 1 | Drive chirp J request |
| drv_resume_k | output | 1 | Drive resume K request |
| connected | output | 1 | Device attached |
| hs_en | output | 1 | High speed negotiated |
| done | output | 1 | One-cycle sequence completion |

## Verification
Resets are run under three device patterns: no K at all, a K shorter than the acceptance time, and a long K that ends partway through. A scoreboard counts the SE0, chirp K, chirp J and resume cycles between completion pulses. Those counts tell a full-speed fallback from a negotiated reset, and they expose an off-by-one slot length or a wrong stopping point for the train. Resume is run with a steady tick and with a gap in the tick, which separates tick-gated timing from cycle counting. Short attach and removal pulses are run against held ones, and requests are raised mid-sequence and while detached, to show which inputs are ignored.

// File: rtl/port_seq_pkg.sv
package port_seq_pkg;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  typedef enum logic [2:0] {
    ST_DETACHED = 3'd0,
    ST_READY    = 3'd1,
    ST_RST_WAIT = 3'd2,
    ST_RST_DEVK = 3'd3,
    ST_RST_TRN  = 3'd4,
    ST_RST_TAIL = 3'd5,
    ST_RST_FS   = 3'd6,
    ST_RESUME   = 3'd7
  } seq_state_e;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/seq_hold_timer.sv
// Counts consecutive tick cycles while cond holds; any cycle without cond clears it.
module seq_hold_timer #(
  parameter int LIMIT = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!cond)                    cnt_d = '0;
    else if (tick && cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = cond && (cnt_q == LIM);
endmodule

// File: rtl/seq_span_timer.sv
// Saturating interval counter: cleared by clr, advanced by run on tick cycles.
module seq_span_timer #(
  parameter int MAXV = 1000,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                              cnt_d = '0;
    else if (run && tick && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/port_seq_top.sv
module port_seq_top
  import port_seq_pkg::*;
#(
  parameter int CONN_TICKS   = 150,
  parameter int DISC_TICKS   = 135,
  parameter int DEVK_TICKS   = 150,
  parameter int RESET_TICKS  = 600000,
  parameter int SLOT_TICKS   = 3000,
  parameter int TAIL_TICKS   = 12000,
  parameter int RESUME_TICKS = 1200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] line_st,
  input  logic       disc_det,
  input  logic       reset_req,
  input  logic       resume_req,
  output logic       drv_se0,
  output logic       drv_chirp_k,
  output logic       drv_chirp_j,
  output logic       drv_resume_k,
  output logic       connected,
  output logic       hs_en,
  output logic       done
);
  localparam int RW = $clog2(RESET_TICKS + 1);
  localparam int SW = $clog2(SLOT_TICKS + 1);
  localparam int MW = $clog2(RESUME_TICKS + 1);
  localparam logic [RW-1:0] RST_LAST  = RW'(RESET_TICKS - 1);
  localparam logic [RW-1:0] TRAIN_END = RW'(RESET_TICKS - TAIL_TICKS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_TICKS - 1);
  localparam logic [MW-1:0] RSM_LAST  = MW'(RESUME_TICKS - 1);

  logic rn;
  seq_state_e st_q, st_d;
  logic ph_q, ph_d, hs_q, hs_d, done_q, done_d;
  logic rst_start, rsm_start, slot_clr;
  logic conn_hit, disc_hit, devk_hit;
  logic in_reset, rst_end, tail_hit, slot_end, rsm_end;
  logic [RW-1:0] rst_cnt;
  logic [SW-1:0] slot_cnt;
  logic [MW-1:0] rsm_cnt;

  seq_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rn));

  seq_hold_timer #(.LIMIT(CONN_TICKS)) u_conn (
    .clk(clk), .rst_n(rn), .tick(tick),
    .cond((st_q == ST_DETACHED) && (line_st == LS_J)), .hit(conn_hit));

  seq_hold_timer #(.LIMIT(DISC_TICKS)) u_disc (
    .clk(clk), .rst_n(rn), .tick(tick),
    .cond((st_q != ST_DETACHED) && disc_det), .hit(disc_hit));

  seq_hold_timer #(.LIMIT(DEVK_TICKS)) u_devk (
    .clk(clk), .rst_n(rn), .tick(tick),
    .cond((st_q == ST_RST_WAIT) && (line_st == LS_K)), .hit(devk_hit));

  seq_span_timer #(.MAXV(RESET_TICKS)) u_rst_tmr (
    .clk(clk), .rst_n(rn), .tick(tick), .clr(rst_start), .run(in_reset), .cnt(rst_cnt));

  seq_span_timer #(.MAXV(SLOT_TICKS)) u_slot_tmr (
    .clk(clk), .rst_n(rn), .tick(tick), .clr(slot_clr),
    .run(st_q == ST_RST_TRN), .cnt(slot_cnt));

  seq_span_timer #(.MAXV(RESUME_TICKS)) u_rsm_tmr (
    .clk(clk), .rst_n(rn), .tick(tick), .clr(rsm_start),
    .run(st_q == ST_RESUME), .cnt(rsm_cnt));

  assign in_reset = (st_q == ST_RST_WAIT) || (st_q == ST_RST_DEVK) ||
                    (st_q == ST_RST_TRN)  || (st_q == ST_RST_TAIL) ||
                    (st_q == ST_RST_FS);
  assign rst_end  = in_reset && tick && (rst_cnt == RST_LAST);
  assign tail_hit = tick && (rst_cnt == TRAIN_END);
  assign slot_end = tick && (slot_cnt == SLOT_LAST);
  assign rsm_end  = tick && (rsm_cnt == RSM_LAST);

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    hs_d      = hs_q;
    done_d    = 1'b0;
    rst_start = 1'b0;
    rsm_start = 1'b0;
    slot_clr  = 1'b0;
    if ((st_q != ST_DETACHED) && disc_hit) begin
      st_d = ST_DETACHED;
      hs_d = 1'b0;
      ph_d = 1'b0;
    end else if (rst_end) begin
      st_d   = ST_READY;
      done_d = 1'b1;
      hs_d   = (st_q == ST_RST_TAIL);
    end else begin
      unique case (st_q)
        ST_DETACHED: if (conn_hit) st_d = ST_READY;
        ST_READY: begin
          if (reset_req) begin
            st_d      = ST_RST_WAIT;
            rst_start = 1'b1;
            hs_d      = 1'b0;
          end else if (resume_req) begin
            st_d      = ST_RESUME;
            rsm_start = 1'b1;
          end
        end
        ST_RST_WAIT: begin
          if (tail_hit)      st_d = ST_RST_FS;
          else if (devk_hit) st_d = ST_RST_DEVK;
        end
        ST_RST_DEVK: begin
          if (tail_hit) st_d = ST_RST_FS;
          else if (line_st != LS_K) begin
            st_d     = ST_RST_TRN;
            slot_clr = 1'b1;
            ph_d     = 1'b0;
          end
        end
        ST_RST_TRN: begin
          if (tail_hit) st_d = ST_RST_TAIL;
          else if (slot_end) begin
            ph_d     = ~ph_q;
            slot_clr = 1'b1;
          end
        end
        ST_RST_TAIL: ;
        ST_RST_FS:   ;
        ST_RESUME: begin
          if (rsm_end) begin
            st_d   = ST_READY;
            done_d = 1'b1;
          end
        end
        default: st_d = ST_DETACHED;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rn) begin
    if (!rn) begin
      st_q   <= ST_DETACHED;
      ph_q   <= 1'b0;
      hs_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      hs_q   <= hs_d;
      done_q <= done_d;
    end
  end

  assign drv_se0      = in_reset && (st_q != ST_RST_TRN);
  assign drv_chirp_k  = (st_q == ST_RST_TRN) && !ph_q;
  assign drv_chirp_j  = (st_q == ST_RST_TRN) && ph_q;
  assign drv_resume_k = (st_q == ST_RESUME);
  assign connected    = (st_q != ST_DETACHED);
  assign hs_en        = hs_q;
  assign done         = done_q;
endmodule

// File: rtl/port_seq_chk.sv
module port_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_st,
  input logic       drv_se0,
  input logic       drv_chirp_k,
  input logic       drv_chirp_j,
  input logic       drv_resume_k,
  input logic       connected,
  input logic       hs_en,
  input logic       done
);
  // R10
  drv_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_se0, drv_chirp_k, drv_chirp_j, drv_resume_k}));

  // R10
  detached_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !connected |-> !(drv_se0 || drv_chirp_k || drv_chirp_j || drv_resume_k || hs_en));

  // R1
  attach_on_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connected) |-> ($past(line_st) == 2'b01));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  j_follows_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_chirp_j) |-> $past(drv_chirp_k));

  // R5
  train_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(drv_chirp_k) && !$past(drv_chirp_j)) |-> ($past(drv_se0) && ($past(line_st) != 2'b10)));

  // R6
  hs_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> done);
endmodule

bind port_seq_top port_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_st(line_st),
  .drv_se0(drv_se0), .drv_chirp_k(drv_chirp_k), .drv_chirp_j(drv_chirp_j),
  .drv_resume_k(drv_resume_k), .connected(connected), .hs_en(hs_en), .done(done));

// File: tb/sim_port_seq_top.sv
`timescale 1ns/1ps
module sim_port_seq_top;
  logic clk = 1'b0;
  logic rst_n, tick, disc_det, reset_req, resume_req;
  logic [1:0] line_st;
  logic drv_se0, drv_chirp_k, drv_chirp_j, drv_resume_k, connected, hs_en, done;

  localparam logic [1:0] SE0 = 2'b00, LJ = 2'b01, LK = 2'b10;

  always #10 clk = ~clk;

  port_seq_top #(
    .CONN_TICKS(4), .DISC_TICKS(3), .DEVK_TICKS(5), .RESET_TICKS(120),
    .SLOT_TICKS(10), .TAIL_TICKS(25), .RESUME_TICKS(30)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_st(line_st), .disc_det(disc_det),
    .reset_req(reset_req), .resume_req(resume_req), .drv_se0(drv_se0),
    .drv_chirp_k(drv_chirp_k), .drv_chirp_j(drv_chirp_j), .drv_resume_k(drv_resume_k),
    .connected(connected), .hs_en(hs_en), .done(done));

  typedef struct {
    int    se0;
    int    ck;
    int    cj;
    int    rk;
    logic  hs;
    string tag;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nerr = 0;
  int c_se0 = 0, c_ck = 0, c_cj = 0, c_rk = 0;
  bit reported = 1'b0;

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: accumulate drive cycles, compare against the scoreboard on each done
  always @(negedge clk) begin
    if (!rst_n || !connected) begin
      c_se0 = 0; c_ck = 0; c_cj = 0; c_rk = 0;
    end else begin
      c_se0 += int'(drv_se0);
      c_ck  += int'(drv_chirp_k);
      c_cj  += int'(drv_chirp_j);
      c_rk  += int'(drv_resume_k);
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3/R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          nchk++;
          if (c_se0 != e.se0 || c_ck != e.ck || c_cj != e.cj || c_rk != e.rk || hs_en !== e.hs) begin
            nerr++;
            $display("FAIL %s actual se0=%0d k=%0d j=%0d rk=%0d hs=%0d expected se0=%0d k=%0d j=%0d rk=%0d hs=%0d",
                     e.tag, c_se0, c_ck, c_cj, c_rk, hs_en, e.se0, e.ck, e.cj, e.rk, e.hs);
          end
        end
        c_se0 = 0; c_ck = 0; c_cj = 0; c_rk = 0;
      end
    end
  end

  task automatic wait_done(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen, {tag, " completion"}, int'(seen), 1);
  endtask

  task automatic push(input int se0, input int ck, input int cj, input int rk,
                      input logic hs, input string tag);
    exp_t e;
    e.se0 = se0; e.ck = ck; e.cj = cj; e.rk = rk; e.hs = hs; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; line_st = SE0; disc_det = 1'b0;
    reset_req = 1'b0; resume_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!connected && !hs_en && !done &&
        {drv_se0, drv_chirp_k, drv_chirp_j, drv_resume_k} == 4'b0,
        "R10 reset state", int'(connected), 0);

    // R1 short J run does not attach
    line_st = LJ; repeat (3) @(negedge clk);
    line_st = SE0; repeat (6) @(negedge clk);
    chk(connected == 1'b0, "R1 short J", int'(connected), 0);
    // R1 held J attaches
    line_st = LJ; repeat (10) @(negedge clk);
    chk(connected == 1'b1, "R1 held J", int'(connected), 1);

    // R3 R8 plain reset with stray requests mid-sequence
    push(120, 0, 0, 0, 1'b0, "R3/R8 plain reset");
    reset_req = 1'b1; line_st = SE0; @(negedge clk); reset_req = 1'b0;
    repeat (50) @(negedge clk);
    reset_req = 1'b1; @(negedge clk); reset_req = 1'b0;
    resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    wait_done("R3");
    line_st = LJ;
    chk(hs_en == 1'b0, "R3 hs after plain reset", int'(hs_en), 0);

    // R4 short device K is not accepted
    @(negedge clk);
    push(120, 0, 0, 0, 1'b0, "R4 short device K");
    reset_req = 1'b1; line_st = LK; @(negedge clk); reset_req = 1'b0;
    repeat (3) @(negedge clk);
    line_st = SE0;
    wait_done("R4");
    line_st = LJ;

    // R5 R6 negotiated reset: 74 chirp cycles (K 40, J 34), 46 SE0
    @(negedge clk);
    push(46, 40, 34, 0, 1'b1, "R5/R6 chirp handshake");
    reset_req = 1'b1; line_st = LK; @(negedge clk); reset_req = 1'b0;
    repeat (20) @(negedge clk);
    line_st = SE0;
    wait_done("R6");
    line_st = LJ;
    chk(hs_en == 1'b1, "R6 hs after handshake", int'(hs_en), 1);

    // R7 resume keeps hs
    @(negedge clk);
    push(0, 0, 0, 30, 1'b1, "R7 resume");
    resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    wait_done("R7");

    // R9 ten cycles without tick stretch resume to 40
    @(negedge clk);
    push(0, 0, 0, 40, 1'b1, "R9 tick-gated resume");
    tick = 1'b0; resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    repeat (10) @(negedge clk);
    tick = 1'b1;
    wait_done("R9");

    // R2 short removal pulse ignored
    @(negedge clk);
    disc_det = 1'b1; repeat (2) @(negedge clk);
    disc_det = 1'b0; repeat (4) @(negedge clk);
    chk(connected && hs_en, "R2 short removal pulse", int'(connected && hs_en), 1);
    // R2 held removal detaches and clears hs
    line_st = SE0;
    disc_det = 1'b1; repeat (6) @(negedge clk);
    disc_det = 1'b0;
    chk(!connected && !hs_en, "R2 removal clears flags", int'(connected || hs_en), 0);

    // R8 request while detached is ignored
    reset_req = 1'b1; @(negedge clk); reset_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!drv_se0 && !connected, "R8 request while detached", int'(drv_se0), 0);

    // R2 removal in the middle of a reset
    line_st = LJ; repeat (8) @(negedge clk);
    chk(connected == 1'b1, "R1 reattach", int'(connected), 1);
    reset_req = 1'b1; line_st = SE0; @(negedge clk); reset_req = 1'b0;
    repeat (30) @(negedge clk);
    chk(drv_se0 == 1'b1, "R3 SE0 during reset", int'(drv_se0), 1);
    disc_det = 1'b1; repeat (6) @(negedge clk);
    disc_det = 1'b0;
    chk(!connected && !drv_se0 && !hs_en, "R2 removal mid-reset", int'(connected || drv_se0), 0);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    report();
  end
endmodule